// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This block watches a set of general-purpose input pins, organised as up to sixteen groups of up to eight pins, and turns activity on them into interrupt requests. Each pin is given its own trigger condition (a level or an edge), a mask bit and a pending bit. Pin inputs are synchronised into the clock domain, evaluated against their trigger condition every cycle, and latched into pending state. All pending, unmasked pins merge into one registered interrupt line.

Software reaches the block through a 32-bit single-cycle register port. A service register names the pin that should be handled first: a 1-based group number and a pin index, or zero when nothing is waiting. Software reads it, handles that pin, and clears its pending bit with a write-1-to-clear store.

Top module: `eint_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit reads 0, every trigger field reads 0, the service register reads 0 and `irq_o` is low; with all inputs held high nothing becomes pending.
- R2: Group g has a configuration word at byte address 0x700+4g, a mask word at 0x900+4g and a pending word at 0xA00+4g; pin p of a group uses configuration bits [4p+3:4p] and bit p of the mask and pending words; configuration words read back what was written.
- R3: Trigger code 0 sets pending while the synchronised input is low, 1 while it is high, 2 on a high-to-low change, 3 on a low-to-high change, 4 on either change.
- R4: Trigger codes 5 to 15 never set pending, whatever the input does.
- R5: An edge-triggered pending bit stays set until software clears it; a level-triggered pending bit is set again in every cycle the level condition holds, even right after a clear.
- R6: Writing the pending word clears exactly those pending bits whose data bit is 1; the other bits are unchanged.
- R7: A mask bit of 1 keeps its pin out of `irq_o` and the service register, while the pin's pending bit still records events; writing the mask bit to 0 unmasks the pin.
- R8: The service register at 0xB08 holds the pin index in bits [2:0] and the group number plus 1 in bits [7:3] for the pending, unmasked pin in the lowest-numbered group and, within that group, the lowest-numbered pin; it reads 0 when no such pin exists.
- R9: `irq_o` is high in a cycle exactly when at least one pin was pending and unmasked in the cycle before.
- R10: An input change applied after a clock edge is visible in the pending word after the third following rising edge, and on `irq_o` after the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_i | input | NUM_GROUPS*PINS_PER_GROUP | Pin inputs, pin p of group g at bit g*PINS_PER_GROUP+p |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the pin inputs are held stable while reset is active and that no pending-word write arrives in the cycle reset is released, so the first cycle after reset has no clear or edge history to account for. The stimulus drives pins and register accesses only just after a falling clock edge, keeps all pins high while idle so that the reset trigger code (low level) stays quiet, and returns every group it touched to its reset configuration, masked and cleared, before the next trial starts. Random trials pick group, pin, trigger code, mask setting and a two-step input pattern; directed cases cover latency, priority, single-bit clears and unsupported codes.

// File: rtl/eint_pkg.sv
package eint_pkg;

    // Trigger codes held in the 4-bit per-pin configuration field
    typedef enum logic [3:0] {
        TRG_LOW  = 4'd0,
        TRG_HIGH = 4'd1,
        TRG_FALL = 4'd2,
        TRG_RISE = 4'd3,
        TRG_BOTH = 4'd4
    } trig_e;

    localparam int TRG_W = 4;

    // Register block base addresses (byte addresses)
    localparam logic [11:0] BASE_CFG  = 12'h700;
    localparam logic [11:0] BASE_MASK = 12'h900;
    localparam logic [11:0] BASE_PEND = 12'hA00;
    localparam logic [11:0] ADDR_SVC  = 12'hB08;

    // Service word layout
    localparam int SVC_PIN_W = 3;
    localparam int SVC_GRP_W = 5;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    // stage1/stage2 form the synchroniser, stage3 is the delayed copy
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
        logic [W-1:0] stage3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.stage1 = din;
        sy_d.stage2 = sy_q.stage1;
        sy_d.stage3 = sy_q.stage2;
    end

    // Reset to ones: idle pins are high, so no spurious edge or low level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign cur  = sy_q.stage2;
    assign prev = sy_q.stage3;

endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int N = 128
) (
    input  logic [N*TRG_W-1:0] cfg,
    input  logic [N-1:0]       cur,
    input  logic [N-1:0]       prev,
    output logic [N-1:0]       hit
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [TRG_W-1:0] code;
        assign code = cfg[i*TRG_W +: TRG_W];

        always_comb begin
            case (code)
                TRG_LOW:  hit[i] = ~cur[i];
                TRG_HIGH: hit[i] = cur[i];
                TRG_FALL: hit[i] = prev[i] & ~cur[i];
                TRG_RISE: hit[i] = ~prev[i] & cur[i];
                TRG_BOTH: hit[i] = prev[i] ^ cur[i];
                default:  hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eint_service.sv
module eint_service
    import eint_pkg::*;
#(
    parameter int NG = 16,
    parameter int NP = 8
) (
    input  logic [NG-1:0][NP-1:0]  active,
    output logic                   found,
    output logic [SVC_GRP_W-1:0]   grp,
    output logic [SVC_PIN_W-1:0]   pin
);
    // Scan from the top down so the lowest group and pin are kept last
    always_comb begin
        found = 1'b0;
        grp   = '0;
        pin   = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            for (int p = NP - 1; p >= 0; p--) begin
                if (active[g][p]) begin
                    found = 1'b1;
                    grp   = SVC_GRP_W'(g + 1);
                    pin   = SVC_PIN_W'(p);
                end
            end
        end
    end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_GROUPS     = 16,
    parameter int PINS_PER_GROUP = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] gpio_i,
    input  logic                                 bus_wr,
    input  logic [11:0]                          bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    output logic                                 irq_o
);
    localparam int NG    = NUM_GROUPS;
    localparam int NP    = PINS_PER_GROUP;
    localparam int NPIN  = NG * NP;
    localparam int CFGW  = NP * TRG_W;
    localparam int GW    = (NG > 1) ? $clog2(NG) : 1;
    localparam logic [11:0] SPAN = 12'(4 * NG);

    typedef logic [NG-1:0][NP-1:0] pinvec_t;

    typedef struct packed {
        logic [NG-1:0][CFGW-1:0] cfg;
        pinvec_t                 mask;
        pinvec_t                 pend;
        logic                    irq;
    } state_t;

    state_t st_d, st_q;

    // ---------------- synchroniser and trigger evaluation ----------------
    logic [NPIN-1:0] pin_cur, pin_prev, hit_flat;
    pinvec_t         hit_v;

    eint_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_i),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    eint_detect #(.N(NPIN)) u_detect (
        .cfg (st_q.cfg),
        .cur (pin_cur),
        .prev(pin_prev),
        .hit (hit_flat)
    );

    assign hit_v = hit_flat;

    // ---------------- service encoder ----------------
    pinvec_t              active_v;
    logic                 svc_found;
    logic [SVC_GRP_W-1:0] svc_grp;
    logic [SVC_PIN_W-1:0] svc_pin;

    assign active_v = st_q.pend & ~st_q.mask;

    eint_service #(.NG(NG), .NP(NP)) u_service (
        .active(active_v),
        .found (svc_found),
        .grp   (svc_grp),
        .pin   (svc_pin)
    );

    // ---------------- address decode ----------------
    logic [11:0] off_cfg, off_mask, off_pend;
    logic        sel_cfg, sel_mask, sel_pend, sel_svc;
    logic [9:0]  idx_cfg, idx_mask, idx_pend;

    always_comb begin
        off_cfg  = bus_addr - BASE_CFG;
        off_mask = bus_addr - BASE_MASK;
        off_pend = bus_addr - BASE_PEND;
        sel_cfg  = (bus_addr >= BASE_CFG)  && (off_cfg  < SPAN) && (bus_addr[1:0] == 2'b00);
        sel_mask = (bus_addr >= BASE_MASK) && (off_mask < SPAN) && (bus_addr[1:0] == 2'b00);
        sel_pend = (bus_addr >= BASE_PEND) && (off_pend < SPAN) && (bus_addr[1:0] == 2'b00);
        sel_svc  = (bus_addr == ADDR_SVC);
        idx_cfg  = off_cfg[11:2];
        idx_mask = off_mask[11:2];
        idx_pend = off_pend[11:2];
    end

    // ---------------- next state ----------------
    pinvec_t clr_v;

    always_comb begin
        st_d  = st_q;
        clr_v = '0;
        for (int g = 0; g < NG; g++) begin
            if (bus_wr && sel_cfg && (idx_cfg == 10'(g))) begin
                st_d.cfg[g] = bus_wdata[CFGW-1:0];
            end
            if (bus_wr && sel_mask && (idx_mask == 10'(g))) begin
                st_d.mask[g] = bus_wdata[NP-1:0];
            end
            if (bus_wr && sel_pend && (idx_pend == 10'(g))) begin
                clr_v[g] = bus_wdata[NP-1:0];
            end
            // a new event in the same cycle wins over the clear
            st_d.pend[g] = (st_q.pend[g] & ~clr_v[g]) | hit_v[g];
        end
        st_d.irq = svc_found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NG; g++) begin
            if (sel_cfg && (idx_cfg == 10'(g))) begin
                bus_rdata = 32'(st_q.cfg[g]);
            end
            if (sel_mask && (idx_mask == 10'(g))) begin
                bus_rdata = 32'(st_q.mask[g]);
            end
            if (sel_pend && (idx_pend == 10'(g))) begin
                bus_rdata = 32'(st_q.pend[g]);
            end
        end
        if (sel_svc) begin
            bus_rdata = {24'd0, svc_grp, svc_pin};
        end
    end

    assign irq_o = st_q.irq;

    // ---------------- assertions ----------------
    logic [GW-1:0] svc_gidx;
    assign svc_gidx = GW'(svc_grp - 5'd1);

    // R9: the combined line follows last cycle's encoder result
    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(svc_found));

    // R7 / R8: a reported pin is pending and not masked
    p_service_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_grp != 5'd0) |->
            (!st_q.mask[svc_gidx][svc_pin] && st_q.pend[svc_gidx][svc_pin]));

    // R6: a cleared bit with no new event in that cycle reads zero
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & $past(clr_v & ~hit_v)) == '0);

    // R4: unsupported codes never raise a pending bit
    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        logic [NPIN-1:0]  pend_flat;
        logic [TRG_W-1:0] code_i;
        assign pend_flat = st_q.pend;
        assign code_i    = st_q.cfg[i / NP][(i % NP) * TRG_W +: TRG_W];

        p_no_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(pend_flat[i]) && ($past(code_i) > 4'd4)) |-> !pend_flat[i]);
    end

endmodule

// File: tb/eint_ctrl_test.sv
`timescale 1ns/1ps
module eint_ctrl_test;

    localparam int NG = 16;
    localparam int NP = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NG*NP-1:0] gpio = '1;
    logic           bus_wr = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    eint_ctrl #(.NUM_GROUPS(NG), .PINS_PER_GROUP(NP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio_i   (gpio),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    function automatic logic [11:0] a_cfg(int g);  return 12'(12'h700 + 4 * g); endfunction
    function automatic logic [11:0] a_mask(int g); return 12'(12'h900 + 4 * g); endfunction
    function automatic logic [11:0] a_pend(int g); return 12'(12'hA00 + 4 * g); endfunction
    localparam logic [11:0] A_SVC = 12'hB08;

    // configuration word with every pin unsupported except one
    function automatic logic [31:0] cfg_word(logic [31:0] base, int p, int code);
        logic [31:0] w = base;
        w[4*p +: 4] = 4'(code);
        return w;
    endfunction

    // expected pending after pin goes to a, is cleared, then goes to b
    function automatic bit exp_pend(int code, bit a, bit b);
        case (code)
            0: return (!a) || (!b);
            1: return a || b;
            2: return a && !b;
            3: return !a && b;
            4: return a != b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] svc_word(int g, int p);
        return 32'(((g + 1) << 3) | p);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic set_pin(int g, int p, bit v);
        gpio[g*NP + p] = v;
    endtask

    task automatic restore(int g);
        for (int p = 0; p < NP; p++) set_pin(g, p, 1'b1);
        idle(6);
        wr(a_cfg(g), 32'h0);
        wr(a_mask(g), 32'hFF);
        wr(a_pend(g), 32'hFF);
        idle(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(A_SVC, d); check("R1 service", d, 32'd0);
        for (int g = 0; g < NG; g++) begin
            rd(a_cfg(g), d);  check("R1 config", d, 32'd0);
            rd(a_mask(g), d); check("R1 mask", d, 32'hFF);
            rd(a_pend(g), d); check("R1 pending", d, 32'd0);
        end
        idle(6);
        rd(a_pend(0), d); check("R1 quiet with high inputs", d, 32'd0);

        // R2: configuration readback and field placement
        wr(a_cfg(3), 32'h8765_4321);
        rd(a_cfg(3), d); check("R2 config readback", d, 32'h8765_4321);
        rd(a_cfg(4), d); check("R2 neighbour untouched", d, 32'd0);
        wr(a_cfg(3), 32'h0);

        // R10: latency, group 2 pin 5 rising edge, unmasked
        wr(a_cfg(2), cfg_word(32'h7777_7777, 5, 3));
        wr(a_mask(2), 32'h00DF);
        set_pin(2, 5, 1'b0);
        idle(6);
        wr(a_pend(2), 32'hFF);
        idle(2);
        set_pin(2, 5, 1'b1);      // applied after a falling edge
        idle(2);
        rd(a_pend(2), d); check("R10 not yet pending after 2 edges", d, 32'd0);
        idle(1);
        rd(a_pend(2), d); check("R10 pending after 3 edges", d, 32'h20);
        check("R10 irq not yet", {31'd0, irq_o}, 32'd0);
        rd(A_SVC, d); check("R8 service g2 p5", d, svc_word(2, 5));
        idle(1);
        check("R10 irq after 4 edges", {31'd0, irq_o}, 32'd1);

        // R5: edge pending is sticky
        idle(10);
        rd(a_pend(2), d); check("R5 edge stays pending", d, 32'h20);
        wr(a_pend(2), 32'h20);
        rd(a_pend(2), d); check("R5 edge cleared", d, 32'd0);
        idle(2);
        check("R9 irq drops", {31'd0, irq_o}, 32'd0);
        // R5: level re-pends straight after a clear
        wr(a_cfg(2), cfg_word(32'h7777_7777, 5, 1));
        idle(2);
        wr(a_pend(2), 32'h20);
        rd(a_pend(2), d); check("R5 level re-pends", d, 32'h20);
        restore(2);

        // R6 / R7 / R8: priority and single-bit clears
        wr(a_cfg(4), cfg_word(cfg_word(32'h7777_7777, 1, 2), 6, 2));
        wr(a_cfg(9), cfg_word(32'h7777_7777, 0, 2));
        set_pin(4, 1, 1'b0); set_pin(4, 6, 1'b0); set_pin(9, 0, 1'b0);
        idle(6);
        rd(a_pend(9), d); check("R7 masked pin still pends", d, 32'h01);
        rd(A_SVC, d); check("R7 masked gives no service", d, 32'd0);
        check("R7 masked gives no irq", {31'd0, irq_o}, 32'd0);
        wr(a_mask(4), 32'h00);
        wr(a_mask(9), 32'hFE);
        idle(2);
        check("R9 irq with unmasked pins", {31'd0, irq_o}, 32'd1);
        rd(A_SVC, d); check("R8 lowest group then pin", d, svc_word(4, 1));
        wr(a_pend(4), 32'h40);
        rd(a_pend(4), d); check("R6 single bit cleared", d, 32'h02);
        wr(a_pend(4), 32'h02);
        rd(a_pend(4), d); check("R6 second bit cleared", d, 32'h00);
        rd(A_SVC, d); check("R8 next group", d, svc_word(9, 0));
        wr(a_pend(9), 32'h01);
        rd(A_SVC, d); check("R8 none left", d, 32'd0);
        restore(4);
        restore(9);

        // R4: unsupported codes
        for (int c = 5; c < 16; c++) begin
            wr(a_cfg(7), cfg_word(32'h7777_7777, 2, c));
            wr(a_mask(7), 32'h00);
            set_pin(7, 2, 1'b0); idle(6);
            set_pin(7, 2, 1'b1); idle(6);
            rd(a_pend(7), d); check("R4 unsupported code", d, 32'd0);
        end
        restore(7);

        // R3 / R4 / R7 / R8 / R9: random trials
        for (int t = 0; t < 60; t++) begin
            int g = int'($urandom_range(NG - 1));
            int p = int'($urandom_range(NP - 1));
            int code = ($urandom_range(9) < 8) ? int'($urandom_range(4))
                                                : int'($urandom_range(15, 5));
            bit a = 1'($urandom_range(1));
            bit b = 1'($urandom_range(1));
            bit um = 1'($urandom_range(1));
            bit e;
            wr(a_cfg(g), cfg_word(32'h7777_7777, p, code));
            set_pin(g, p, a);
            idle(6);
            wr(a_pend(g), 32'hFF);
            wr(a_mask(g), um ? (32'hFF & ~(32'd1 << p)) : 32'hFF);
            set_pin(g, p, b);
            idle(6);
            e = exp_pend(code, a, b);
            rd(a_pend(g), d);
            check((code > 4) ? "R4 random pending" : "R3 random pending",
                  d, e ? (32'd1 << p) : 32'd0);
            rd(A_SVC, d);
            check("R8 random service", d, (e && um) ? svc_word(g, p) : 32'd0);
            check("R9 random irq", {31'd0, irq_o}, {31'd0, e && um});
            restore(g);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule